// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Comparator

This block decides whether one incoming CAN frame is accepted by one receive mailbox filter. On each frame strobe it compares the frame's identifier, IDE bit and RTR bit against the mailbox filter's identifier and flags. The comparison runs under a mask word. The mask is either the mailbox's own mask or a single global mask, depending on a mask-select input.

A compare-mode input sets how the two flag bits take part. In legacy mode the IDE bits must always agree and RTR is ignored, whatever the mask says. In masked mode both flag bits are compared, and each comparison is subject to its own mask bit. The result is registered. It appears one clock after the strobe and holds until the next strobe. A receive engine instantiates one comparator per mailbox, or reuses one comparator across mailboxes in sequence.

Top module: `can_rx_accept_match`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `match` becomes 0 at that edge. After reset, `match` stays 0 until the first strobe.
- R2: When `frm_vld` is high at a rising edge, `match` takes the comparison result at that edge. When `frm_vld` is low, `match` keeps its value, whatever the other inputs do.
- R3: Mask word layout is: bits 28..0 identifier, bit 29 IDE, bit 30 RTR. An identifier bit with mask bit 1 must be equal in frame and filter. An identifier bit with mask bit 0 is don't-care.
- R4: For a standard frame (`frm_ide` = 0), only identifier bits 28..18 are compared. A difference in bits 17..0 never rejects the frame.
- R5: For an extended frame (`frm_ide` = 1), all identifier bits 28..0 are compared under the mask.
- R6: With `cmp_mode` = 0, a frame whose IDE differs from the filter IDE is rejected, even when mask bit 29 is 0.
- R7: With `cmp_mode` = 0, RTR is never compared. A frame with a differing RTR is accepted even when mask bit 30 is 1.
- R8: With `cmp_mode` = 1, IDE and RTR are compared only where mask bit 29 and mask bit 30 respectively are 1. A differing flag under a mask bit of 0 is accepted.
- R9: With `indiv_en` = 0, `glb_mask` is used and `mb_mask` has no effect. With `indiv_en` = 1, `mb_mask` is used and `glb_mask` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_vld | input | 1 | Frame strobe; samples the comparison |
| frm_id | input | 29 | Frame identifier (standard part in 28..18) |
| frm_ide | input | 1 | Frame IDE bit (1 = extended) |
| frm_rtr | input | 1 | Frame RTR bit |
| flt_id | input | 29 | Filter identifier |
| flt_ide | input | 1 | Filter IDE bit |
| flt_rtr | input | 1 | Filter RTR bit |
| mb_mask | input | 31 | Mailbox mask word |
| glb_mask | input | 31 | Global mask word |
| indiv_en | input | 1 | 1 selects the mailbox mask, 0 selects the global mask |
| cmp_mode | input | 1 | 0 = legacy flag compare, 1 = masked flag compare |
| match | output | 1 | Registered acceptance result |

## Verification
The assertions assume two things about the inputs. First, every input is a known value at each rising edge where `frm_vld` is high. Second, reset is applied before the first strobe. The bench meets both conditions: it drives all inputs only on falling edges, and it holds reset over several cycles at the start. Random filters are built by flipping a few bits of the frame identifier, so that accepts and rejects both occur often. Between strobes the bench changes the inputs on purpose to show that `match` holds its value.

// File: rtl/can_acc_pkg.sv
// Shared constants and types for the acceptance comparator.
// Assumes 29-bit extended and 11-bit standard identifiers by default.
package can_acc_pkg;
    localparam int unsigned CAN_EXT_ID_W = 29;
    localparam int unsigned CAN_STD_ID_W = 11;

    // Flag comparison policy selected by the compare-mode input.
    typedef enum logic {
        FLAG_MODE_LEGACY = 1'b0,
        FLAG_MODE_MASKED = 1'b1
    } flag_mode_e;
endpackage

// File: rtl/can_acc_mask_sel.sv
// Picks the effective mask word: the mailbox mask or the global mask.
// Assumes both words share one layout (identifier bits low, IDE, then RTR).
module can_acc_mask_sel #(
    parameter int unsigned MASK_W = 31
) (
    input  logic [MASK_W-1:0] mb_mask,
    input  logic [MASK_W-1:0] glb_mask,
    input  logic              indiv_en,
    output logic [MASK_W-1:0] eff_mask
);
    // Mask source selection.
    always_comb begin
        if (indiv_en) eff_mask = mb_mask;
        else          eff_mask = glb_mask;
    end
endmodule

// File: rtl/can_acc_id_cmp.sv
// Masked identifier comparison, one slice per bit.
// The top STD_W bits always take part. The lower bits take part only for
// extended frames. Assumes STD_W <= ID_W.
module can_acc_id_cmp #(
    parameter int unsigned ID_W  = 29,
    parameter int unsigned STD_W = 11
) (
    input  logic [ID_W-1:0] frm_id,
    input  logic [ID_W-1:0] flt_id,
    input  logic [ID_W-1:0] id_mask,
    input  logic            frm_ide,
    output logic            id_ok
);
    localparam int unsigned EXT_LO = ID_W - STD_W;

    logic [ID_W-1:0] bit_bad;

    genvar gi;
    generate
        for (gi = 0; gi < ID_W; gi++) begin : g_bit
            if (gi >= EXT_LO) begin : g_std
                // Standard-field bit: compared for every frame format.
                always_comb bit_bad[gi] = id_mask[gi] & (frm_id[gi] ^ flt_id[gi]);
            end else begin : g_ext
                // Extension bit: compared only for extended frames.
                always_comb bit_bad[gi] = frm_ide & id_mask[gi] & (frm_id[gi] ^ flt_id[gi]);
            end
        end
    endgenerate

    // Identifier accepted when no enabled bit differs.
    always_comb id_ok = ~|bit_bad;
endmodule

// File: rtl/can_acc_flag_cmp.sv
// IDE/RTR comparison under the selected flag policy.
// Legacy: IDE must be equal and RTR is ignored, with no masking.
// Masked: each flag is compared only where its mask bit is set.
module can_acc_flag_cmp
    import can_acc_pkg::*;
(
    input  logic cmp_mode,
    input  logic frm_ide,
    input  logic flt_ide,
    input  logic frm_rtr,
    input  logic flt_rtr,
    input  logic ide_mask,
    input  logic rtr_mask,
    output logic ide_ok,
    output logic rtr_ok
);
    flag_mode_e mode;
    always_comb mode = flag_mode_e'(cmp_mode);

    // Flag verdicts for the active policy.
    always_comb begin
        case (mode)
            FLAG_MODE_MASKED: begin
                ide_ok = ~(ide_mask & (frm_ide ^ flt_ide));
                rtr_ok = ~(rtr_mask & (frm_rtr ^ flt_rtr));
            end
            default: begin
                ide_ok = ~(frm_ide ^ flt_ide);
                rtr_ok = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/can_rx_accept_match.sv
// Acceptance comparator for one receive mailbox filter.
// Combines mask selection, identifier and flag comparison, then registers
// the verdict on each frame strobe. Synchronous active-low reset.
// Assumes inputs are stable around the rising edge when frm_vld is high.
module can_rx_accept_match
    import can_acc_pkg::*;
#(
    parameter int unsigned ID_W  = CAN_EXT_ID_W,
    parameter int unsigned STD_W = CAN_STD_ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_vld,
    input  logic [ID_W-1:0]   frm_id,
    input  logic              frm_ide,
    input  logic              frm_rtr,
    input  logic [ID_W-1:0]   flt_id,
    input  logic              flt_ide,
    input  logic              flt_rtr,
    input  logic [ID_W+1:0]   mb_mask,
    input  logic [ID_W+1:0]   glb_mask,
    input  logic              indiv_en,
    input  logic              cmp_mode,
    output logic              match
);
    localparam int unsigned MASK_W  = ID_W + 2;
    localparam int unsigned IDE_BIT = ID_W;
    localparam int unsigned RTR_BIT = ID_W + 1;

    logic [MASK_W-1:0] eff_mask;
    logic              id_ok;
    logic              ide_ok;
    logic              rtr_ok;
    logic              hit;

    can_acc_mask_sel #(.MASK_W(MASK_W)) u_mask (
        .mb_mask  (mb_mask),
        .glb_mask (glb_mask),
        .indiv_en (indiv_en),
        .eff_mask (eff_mask)
    );

    can_acc_id_cmp #(.ID_W(ID_W), .STD_W(STD_W)) u_id (
        .frm_id  (frm_id),
        .flt_id  (flt_id),
        .id_mask (eff_mask[ID_W-1:0]),
        .frm_ide (frm_ide),
        .id_ok   (id_ok)
    );

    can_acc_flag_cmp u_flag (
        .cmp_mode (cmp_mode),
        .frm_ide  (frm_ide),
        .flt_ide  (flt_ide),
        .frm_rtr  (frm_rtr),
        .flt_rtr  (flt_rtr),
        .ide_mask (eff_mask[IDE_BIT]),
        .rtr_mask (eff_mask[RTR_BIT]),
        .ide_ok   (ide_ok),
        .rtr_ok   (rtr_ok)
    );

    // Overall verdict from the three partial checks.
    always_comb hit = id_ok & ide_ok & rtr_ok;

    // Result register: clear on reset, capture on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       match <= 1'b0;
        else if (frm_vld) match <= hit;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !match);

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld |=> $stable(match));

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |=> match == $past(hit));

    // R3
    exact_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld && frm_id == flt_id && frm_ide == flt_ide && frm_rtr == flt_rtr |=> match);

    // R6
    ide_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld && !cmp_mode && (frm_ide != flt_ide) |=> !match);

    // R7
    rtr_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_mode |-> rtr_ok);
endmodule

// File: tb/sim_can_rx_accept_match.sv
module sim_can_rx_accept_match;
    localparam int ID_W = 29;
    localparam int MW   = 31;

    logic clk = 1'b0;
    logic rst_n;
    logic frm_vld;
    logic [ID_W-1:0] frm_id, flt_id;
    logic frm_ide, frm_rtr, flt_ide, flt_rtr;
    logic [MW-1:0] mb_mask, glb_mask;
    logic indiv_en, cmp_mode;
    logic match;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    can_rx_accept_match u0 (
        .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld),
        .frm_id(frm_id), .frm_ide(frm_ide), .frm_rtr(frm_rtr),
        .flt_id(flt_id), .flt_ide(flt_ide), .flt_rtr(flt_rtr),
        .mb_mask(mb_mask), .glb_mask(glb_mask),
        .indiv_en(indiv_en), .cmp_mode(cmp_mode), .match(match)
    );

    // Reference verdict taken from the requirements.
    function automatic logic ref_hit(
        input logic [ID_W-1:0] fi, input logic fe, input logic fr,
        input logic [ID_W-1:0] li, input logic le, input logic lr,
        input logic [MW-1:0] im, input logic [MW-1:0] gm,
        input logic en, input logic md);
        logic [MW-1:0] m;
        logic ok;
        m  = en ? im : gm;
        ok = 1'b1;
        for (int i = 0; i < ID_W; i++)
            if ((fe || i >= 18) && m[i] && fi[i] != li[i]) ok = 1'b0;
        if (!md) begin
            if (fe != le) ok = 1'b0;
        end else begin
            if (m[29] && fe != le) ok = 1'b0;
            if (m[30] && fr != lr) ok = 1'b0;
        end
        return ok;
    endfunction

    task automatic check(input string req, input logic exp);
        n_run++;
        if (match !== exp) begin
            n_fail++;
            $display("FAIL %s: match=%b expected=%b", req, match, exp);
        end
    endtask

    // Applies one strobe, then checks the registered result.
    task automatic strobe(input string req);
        logic e;
        e = ref_hit(frm_id, frm_ide, frm_rtr, flt_id, flt_ide, flt_rtr,
                    mb_mask, glb_mask, indiv_en, cmp_mode);
        frm_vld = 1'b1;
        @(negedge clk);
        frm_vld = 1'b0;
        check(req, e);
    endtask

    task automatic base(input logic ide);
        frm_id = 29'h0ABC_1234; flt_id = 29'h0ABC_1234;
        frm_ide = ide; flt_ide = ide; frm_rtr = 1'b0; flt_rtr = 1'b0;
        mb_mask = '1; glb_mask = '1; indiv_en = 1'b1; cmp_mode = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: match=%b expected=done", match);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic held;
        void'($urandom(32'd4242));
        rst_n = 1'b0; frm_vld = 1'b0; base(1'b1);
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0);

        // R3 exact equality accepted
        base(1'b1); strobe("R3");
        // R4 standard frame ignores bits 17..0
        base(1'b0); frm_id[5] = ~frm_id[5]; frm_id[17] = ~frm_id[17]; strobe("R4");
        base(1'b0); frm_id[18] = ~frm_id[18]; strobe("R4");
        // R5 extended frame compares low bits
        base(1'b1); frm_id[0] = ~frm_id[0]; strobe("R5");
        // R3 don't-care bit
        base(1'b1); frm_id[0] = ~frm_id[0]; mb_mask[0] = 1'b0; strobe("R3");
        // R6 legacy IDE mismatch ignores mask
        base(1'b1); flt_ide = 1'b0; mb_mask[29] = 1'b0; strobe("R6");
        // R7 legacy RTR ignored
        base(1'b1); frm_rtr = 1'b1; strobe("R7");
        // R8 masked mode
        base(1'b1); cmp_mode = 1'b1; flt_ide = 1'b0; strobe("R8");
        base(1'b1); cmp_mode = 1'b1; flt_ide = 1'b0; mb_mask[29] = 1'b0; strobe("R8");
        base(1'b1); cmp_mode = 1'b1; frm_rtr = 1'b1; strobe("R8");
        base(1'b1); cmp_mode = 1'b1; frm_rtr = 1'b1; mb_mask[30] = 1'b0; strobe("R8");
        // R9 mask source
        base(1'b1); frm_id[3] = ~frm_id[3]; glb_mask = '0; indiv_en = 1'b0; strobe("R9");
        base(1'b1); frm_id[3] = ~frm_id[3]; glb_mask = '0; indiv_en = 1'b1; strobe("R9");
        base(1'b1); frm_id[3] = ~frm_id[3]; mb_mask = '0; indiv_en = 1'b0; strobe("R9");

        // R2 hold: result 1, then mismatching inputs without strobe
        base(1'b1); strobe("R2");
        held = match;
        flt_id = ~flt_id; flt_ide = ~flt_ide;
        repeat (4) @(negedge clk);
        check("R2", held);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            frm_id  = ID_W'($urandom);
            flt_id  = frm_id;
            if ($urandom_range(0, 1) != 0) flt_id[$urandom_range(0, ID_W-1)] ^= 1'b1;
            if ($urandom_range(0, 3) == 0) flt_id[$urandom_range(0, ID_W-1)] ^= 1'b1;
            frm_ide = 1'($urandom); flt_ide = ($urandom_range(0, 3) == 0) ? ~frm_ide : frm_ide;
            frm_rtr = 1'($urandom); flt_rtr = 1'($urandom);
            mb_mask  = MW'($urandom) | MW'($urandom);
            glb_mask = MW'($urandom) | MW'($urandom);
            indiv_en = 1'($urandom); cmp_mode = 1'($urandom);
            strobe("R3/R5 random");
            if ($urandom_range(0, 7) == 0) begin
                held = match;
                frm_id = ~frm_id;
                @(negedge clk);
                check("R2", held);
            end
        end

        // R1 reset mid-run clears a set result
        base(1'b1); strobe("R1");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule